// File: doc/BRIEF.md
# Serial-In Latched-Output Shift Register

This block converts a serial bit stream into a parallel word. Bits enter a chain of shift stages on the rising edge of a shift clock. A second register, loaded on the rising edge of its own storage clock, copies the whole chain at once and drives the parallel outputs. Between storage edges the outputs therefore hold steady, however many bits are shifted. The last shift stage is also brought out as a serial output, so several blocks can be chained into a longer register.

Each register has its own asynchronous active-low clear, and each clear acts on its own register only. There is no output enable, so the parallel outputs always show the storage register. The stage count is a parameter with a default of 8.

Top module: `latched_shift_reg`

## Requirements
- R1: On each rising edge of `shift_clk` with `shift_clr_n` high, `ser_in` is captured into stage 0 and every stage n takes the value that stage n-1 held before the edge. Shifting a byte in from its bit 7 down to its bit 0 leaves stage n holding byte bit n.
- R2: `ser_out` always equals the last shift stage. After a shift it shows the value that the second-to-last stage held before that edge.
- R3: On each rising edge of `store_clk` with `store_clr_n` high, the storage register captures all shift stages, and `par_out[n]` shows stored stage n. Between storage edges `par_out` does not change while shifting goes on.
- R4: While `shift_clr_n` is low, all shift stages and `ser_out` read 0 at once, with no clock edge needed, and `par_out` keeps its value.
- R5: While `store_clr_n` is low, `par_out` reads 0 at once. The shift stages and `ser_out` are unchanged, and a later storage edge after release loads the shift contents held from before the clear.
- R6: A rising edge of `store_clk` while the shift register is held clear loads all zeros into the storage register.
- R7: When both clocks rise at the same instant, the storage register captures the shift contents as they were before that edge's shift, so it trails the shift register by one edge.
- R8: Each clear overrides its own clock. Shift clock edges during a shift clear leave the stages at 0, and storage clock edges during a storage clear leave `par_out` at 0.
- R9: With two 8-stage blocks chained (serial output of the first into the serial input of the second) and sharing clocks, after 16 shift edges and one storage edge the second block's `par_out` holds the first 8 bits sent and the first block's holds the last 8. The earliest bit sits in bit 7 of the second block.
- R10: With both clears low, `par_out` and `ser_out` read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ser_in | input | 1 | Serial data into stage 0 |
| shift_clk | input | 1 | Shift clock, rising edge active |
| store_clk | input | 1 | Storage clock, rising edge active |
| shift_clr_n | input | 1 | Asynchronous active-low clear of the shift stages |
| store_clr_n | input | 1 | Asynchronous active-low clear of the storage register |
| par_out | output | STAGES | Parallel outputs from the storage register |
| ser_out | output | 1 | Last shift stage, used for chaining |

## Verification
The hardest case to reach from the ports is the one where both clocks rise in the same time step. There the storage register has to take the old chain contents, not the freshly shifted ones. The bench raises both clock nets in one statement and compares the parallel outputs with the shift contents from one edge earlier, which it worked out by hand. It also pulses the storage clock while the shift clear is held low, and pulses each clock during its own clear. Then it releases the clear and reads the untouched register out through a storage edge or the serial output.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
    // Default number of shift and storage stages.
    localparam int unsigned LSR_DEF_STAGES = 8;
endpackage

// File: rtl/lsr_shift_core.sv
module lsr_shift_core #(
    parameter int unsigned STAGES = lsr_pkg::LSR_DEF_STAGES
) (
    input  logic              shift_clk,
    input  logic              clear_n,
    input  logic              din,
    output logic [STAGES-1:0] stages,
    output logic              tail
);
    typedef struct packed {
        logic [STAGES-1:0] cells;
    } shift_state_t;

    shift_state_t      sr_d;
    shift_state_t      sr_q;
    logic [STAGES-1:0] moved;

    // Each stage takes its lower neighbour's value; stage 0 takes the input.
    assign moved[0] = din;
    for (genvar g = 1; g < STAGES; g++) begin : g_link
        assign moved[g] = sr_q.cells[g-1];
    end

    always_comb begin
        sr_d       = sr_q;
        sr_d.cells = moved;
    end

    always_ff @(posedge shift_clk or negedge clear_n) begin
        if (!clear_n) sr_q <= '0;
        else          sr_q <= sr_d;
    end

    assign stages = sr_q.cells;
    assign tail   = sr_q.cells[STAGES-1];

    // Set by a clear and dropped by the first edge after it, so the checks
    // below look back only over edges that had no clear between them.
    logic fresh_q;
    always_ff @(posedge shift_clk or negedge clear_n) begin
        if (!clear_n) fresh_q <= 1'b1;
        else          fresh_q <= 1'b0;
    end

    // R1: stage 0 holds the input sampled at the previous edge
    assert_stage0_capture_R1: assert property (@(posedge shift_clk) disable iff (!clear_n)
        !fresh_q |-> sr_q.cells[0] == $past(din));

    // R2: every upper stage, the tail included, holds its neighbour's old value
    assert_stage_advance_R2: assert property (@(posedge shift_clk) disable iff (!clear_n)
        !fresh_q |-> sr_q.cells[STAGES-1:1] == $past(sr_q.cells[STAGES-2:0]));
endmodule

// File: rtl/lsr_store_core.sv
module lsr_store_core #(
    parameter int unsigned STAGES = lsr_pkg::LSR_DEF_STAGES
) (
    input  logic              store_clk,
    input  logic              clear_n,
    input  logic [STAGES-1:0] snap,
    output logic [STAGES-1:0] held
);
    typedef struct packed {
        logic [STAGES-1:0] word;
    } store_state_t;

    store_state_t st_d;
    store_state_t st_q;

    always_comb begin
        st_d      = st_q;
        st_d.word = snap;
    end

    always_ff @(posedge store_clk or negedge clear_n) begin
        if (!clear_n) st_q <= '0;
        else          st_q <= st_d;
    end

    assign held = st_q.word;

    logic fresh_q;
    always_ff @(posedge store_clk or negedge clear_n) begin
        if (!clear_n) fresh_q <= 1'b1;
        else          fresh_q <= 1'b0;
    end

    // R3: the held word equals the chain contents seen at the previous storage edge
    assert_capture_word_R3: assert property (@(posedge store_clk) disable iff (!clear_n)
        !fresh_q |-> st_q.word == $past(snap));
endmodule

// File: rtl/latched_shift_reg.sv
module latched_shift_reg #(
    parameter int unsigned STAGES = lsr_pkg::LSR_DEF_STAGES
) (
    input  logic              ser_in,
    input  logic              shift_clk,
    input  logic              store_clk,
    input  logic              shift_clr_n,
    input  logic              store_clr_n,
    output logic [STAGES-1:0] par_out,
    output logic              ser_out
);
    logic [STAGES-1:0] chain_bits;

    lsr_shift_core #(.STAGES(STAGES)) u_shift (
        .shift_clk (shift_clk),
        .clear_n   (shift_clr_n),
        .din       (ser_in),
        .stages    (chain_bits),
        .tail      (ser_out)
    );

    lsr_store_core #(.STAGES(STAGES)) u_store (
        .store_clk (store_clk),
        .clear_n   (store_clr_n),
        .snap      (chain_bits),
        .held      (par_out)
    );

    // R6: a storage edge taken while the shift register is cleared leaves zeros
    assert_zero_load_R6: assert property (@(posedge store_clk) disable iff (!store_clr_n)
        !shift_clr_n |=> par_out == '0);
endmodule

// File: tb/latched_shift_reg_test.sv
module latched_shift_reg_test;
    localparam int N = 8;
    localparam int WATCH_LIMIT = 200000;

    logic         clk = 1'b0;
    logic         ser_in = 1'b0, sh_clk = 1'b0, st_clk = 1'b0;
    logic         sh_clr_n = 1'b0, st_clr_n = 1'b0;
    logic [N-1:0] par_out;
    logic         ser_out;

    logic         ch_in = 1'b0, ch_sh = 1'b0, ch_st = 1'b0, ch_clr_n = 1'b0;
    logic [N-1:0] ch_par_a, ch_par_b;
    logic         ch_link, ch_tail;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    latched_shift_reg #(.STAGES(N)) uut (
        .ser_in(ser_in), .shift_clk(sh_clk), .store_clk(st_clk),
        .shift_clr_n(sh_clr_n), .store_clr_n(st_clr_n),
        .par_out(par_out), .ser_out(ser_out)
    );

    latched_shift_reg #(.STAGES(N)) chain_a (
        .ser_in(ch_in), .shift_clk(ch_sh), .store_clk(ch_st),
        .shift_clr_n(ch_clr_n), .store_clr_n(ch_clr_n),
        .par_out(ch_par_a), .ser_out(ch_link)
    );

    latched_shift_reg #(.STAGES(N)) chain_b (
        .ser_in(ch_link), .shift_clk(ch_sh), .store_clk(ch_st),
        .shift_clr_n(ch_clr_n), .store_clr_n(ch_clr_n),
        .par_out(ch_par_b), .ser_out(ch_tail)
    );

    typedef struct packed {
        logic [7:0] pattern;
        logic [7:0] want_par;
        logic       want_tail;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'hA5, 8'hA5, 1'b1},
        '{8'h00, 8'h00, 1'b0},
        '{8'hFF, 8'hFF, 1'b1},
        '{8'h01, 8'h01, 1'b0},
        '{8'h80, 8'h80, 1'b1},
        '{8'h5A, 8'h5A, 1'b0}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic shift_pulse(input logic b);
        ser_in = b;
        #1 sh_clk = 1'b1;
        #2 sh_clk = 1'b0;
        #1;
    endtask

    task automatic store_pulse();
        #1 st_clk = 1'b1;
        #2 st_clk = 1'b0;
        #1;
    endtask

    task automatic both_pulse(input logic b);
        ser_in = b;
        #1 begin sh_clk = 1'b1; st_clk = 1'b1; end
        #2 begin sh_clk = 1'b0; st_clk = 1'b0; end
        #1;
    endtask

    task automatic chain_shift(input logic b);
        ch_in = b;
        #1 ch_sh = 1'b1;
        #2 ch_sh = 1'b0;
        #1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCH_LIMIT && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCH_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] prev;
        logic [15:0] word;

        // R10: both clears held at start
        #3;
        chk("R10 par_out in clear", par_out, 8'h00);
        chk("R10 ser_out in clear", {7'b0, ser_out}, 8'h00);
        sh_clr_n = 1'b1;
        st_clr_n = 1'b1;
        #2;

        // Table walk: R1, R2, R3
        prev = 8'h00;
        foreach (VECS[k]) begin
            for (int i = N - 1; i >= 0; i--) shift_pulse(VECS[k].pattern[i]);
            chk("R2 tail after byte", {7'b0, ser_out}, {7'b0, VECS[k].want_tail});
            chk("R3 par held before store", par_out, prev);
            store_pulse();
            chk("R1 R3 par after store", par_out, VECS[k].want_par);
            prev = VECS[k].want_par;
        end

        // R2: contents 5A, shift 0 -> tail shows old stage 6 (1)
        shift_pulse(1'b0);
        chk("R2 tail shows old stage6", {7'b0, ser_out}, 8'h01);
        store_pulse();
        chk("R3 store B4", par_out, 8'hB4);

        // R4, R8, R6: shift clear
        shift_pulse(1'b1);                       // chain 69
        sh_clr_n = 1'b0;
        #1;
        chk("R4 ser_out cleared", {7'b0, ser_out}, 8'h00);
        chk("R4 par_out kept", par_out, 8'hB4);
        shift_pulse(1'b1);
        chk("R8 shift clock ignored in clear", {7'b0, ser_out}, 8'h00);
        chk("R4 par_out kept after clocks", par_out, 8'hB4);
        store_pulse();
        chk("R6 store while shift cleared", par_out, 8'h00);
        sh_clr_n = 1'b1;
        #2;
        store_pulse();
        chk("R8 shift stayed zero", par_out, 8'h00);

        // R5, R8: storage clear
        for (int i = N - 1; i >= 0; i--) shift_pulse(word_bit(8'hC3, i));
        store_pulse();
        chk("R3 store C3", par_out, 8'hC3);
        shift_pulse(1'b1);                       // chain 87, tail = 1
        st_clr_n = 1'b0;
        #1;
        chk("R5 par_out cleared", par_out, 8'h00);
        chk("R5 ser_out unchanged", {7'b0, ser_out}, 8'h01);
        store_pulse();
        chk("R8 store clock ignored in clear", par_out, 8'h00);
        st_clr_n = 1'b1;
        #2;
        chk("R5 par_out zero after release", par_out, 8'h00);
        store_pulse();
        chk("R5 shift contents kept", par_out, 8'h87);

        // R7: tied clocks, storage trails by one edge
        both_pulse(1'b0);
        chk("R7 first tied edge", par_out, 8'h87);
        both_pulse(1'b1);
        chk("R7 second tied edge", par_out, 8'h0E);
        both_pulse(1'b1);
        chk("R7 third tied edge", par_out, 8'h1D);

        // R9: two chained blocks
        #2 ch_clr_n = 1'b1;
        #2;
        word = 16'hB2E7;
        for (int i = 15; i >= 0; i--) chain_shift(word[i]);
        #1 ch_st = 1'b1;
        #2 ch_st = 1'b0;
        #1;
        chk("R9 downstream holds first byte", ch_par_b, 8'hB2);
        chk("R9 upstream holds last byte", ch_par_a, 8'hE7);
        chk("R9 downstream tail earliest bit", {7'b0, ch_tail}, 8'h01);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic logic word_bit(input logic [7:0] w, input int idx);
        return w[idx];
    endfunction
endmodule